// File: doc/BRIEF.md
# SMT Multi-Thread Issue Selector

This block decides, in every clock cycle, which ready instructions from a shared instruction queue enter the machine's issue slots. The queue holds entries from several hardware threads at once. Each entry carries a valid bit, a ready bit, a thread id, an age, a functional-unit class, a branch flag and a speculative flag. Candidates from every thread compete for the same slots in the same cycle. No thread has a quota.

The execution resources are a pool of shared, fully pipelined functional units of four types. Each type has its own count and its own result latency. A candidate is granted only if a unit of its class is still free in that cycle. A selectable policy puts the candidates in order before units are handed out. The three policies are oldest-first, branches-first and speculative-last.

The block reports the grants per slot, the entries and units used, and a per-unit schedule. That schedule shows which units have work in flight and when each result returns. The block also keeps two running waste counters. One counts cycles with no slot filled. The other sums the empty slots of cycles that are only partly filled.

Top module: `smt_issue_select`

## Requirements
- R1: Only an entry with both valid and ready set can be granted. At most 4 entries are granted per cycle, and no entry is granted twice.
- R2: Class codes are 0 integer ALU, 1 multiply/divide, 2 memory port and 3 floating point. Unit indices run 0-3 for the ALUs, 4 for the multiplier, 5-7 for the memory ports and 8-9 for the FP ALUs. A granted entry takes the lowest-index unit of its class whose availability bit is set and that is not already taken in that cycle. Each unit takes at most one entry per cycle.
- R3: Candidates are visited in priority order. A candidate with no free unit of its class is skipped, and lower-priority candidates of other classes may still be granted.
- R4: Under policy 0, and under the unused code 3, a larger age value (an older entry) has higher priority.
- R5: Under policy 1, every branch outranks every non-branch, and age order applies within each group.
- R6: Under policy 2, every non-speculative entry outranks every speculative entry, and age order applies within each group.
- R7: Ties are resolved first by larger age, then by lower thread id, then by lower queue index.
- R8: Slot k holds the k-th granted entry in priority order. Filled slots are contiguous from slot 0. Each slot reports the entry index and the unit index.
- R9: Entries from different threads can be granted in the same cycle, with no limit per thread.
- R10: A unit's done flag is high exactly L cycles after that unit's grant appeared on the outputs. L is 1 for an ALU, 3 for the multiplier, 2 for a memory port and 5 for an FP ALU. The unit's in-flight flag is high in each of those L cycles.
- R11: A cycle with no grant adds 1 to the vertical-waste counter. A cycle with n grants, where 0 < n < 4, adds 4 - n to the horizontal-waste counter.
- R12: Grants appear one clock after the inputs that produced them. The policy is read anew in each cycle and can change in any cycle.
- R13: While reset is high, every grant, in-flight, done and counter output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| policy_i | input | 2 | Ordering policy: 0 oldest, 1 branches first, 2 speculative last |
| ent_valid_i | input | 8 | Entry holds an instruction |
| ent_ready_i | input | 8 | Entry operands are ready |
| ent_tid_i | input | 16 | Thread id per entry, 2 bits each |
| ent_age_i | input | 32 | Age per entry, 4 bits each, larger is older |
| ent_cls_i | input | 16 | Unit class per entry, 2 bits each |
| ent_branch_i | input | 8 | Entry is a branch |
| ent_spec_i | input | 8 | Entry is speculative or optimistic |
| unit_avail_i | input | 10 | Unit may accept an instruction this cycle |
| slot_vld_o | output | 4 | Slot holds a grant |
| slot_idx_o | output | 12 | Queue index per slot, 3 bits each |
| slot_unit_o | output | 16 | Unit index per slot, 4 bits each |
| ent_issued_o | output | 8 | Entry was granted |
| unit_issue_o | output | 10 | Unit received an instruction |
| unit_inflight_o | output | 10 | Unit has an instruction in flight |
| unit_done_o | output | 10 | Unit result becomes available |
| vert_waste_o | output | 16 | Count of cycles with no slot filled |
| horiz_waste_o | output | 16 | Sum of empty slots in partly filled cycles |

## Verification
Assertions check the following in every cycle: each granted entry was valid and ready, each granted unit was available, the slot list agrees with the grant masks and is packed from slot 0, each done flag trails its grant by exactly the unit's latency, and the two waste counters never move in the same cycle. The ordering rules can only be shown by the bench scenarios. These are the three policies, the tie-breaks, skipping a candidate whose class is exhausted, unit choice by lowest index, and a policy change from cycle to cycle. The bench compares every output against a reference model that searches for the best remaining candidate, with directed cases for each rule and random traffic.

// File: rtl/smt_iss_pkg.sv
package smt_iss_pkg;

    typedef enum logic [1:0] {
        CLS_ALU = 2'd0,
        CLS_MUL = 2'd1,
        CLS_MEM = 2'd2,
        CLS_FPU = 2'd3
    } fu_cls_e;

    typedef enum logic [1:0] {
        POL_OLDEST    = 2'd0,
        POL_BR_FIRST  = 2'd1,
        POL_SPEC_LAST = 2'd2,
        POL_SPARE     = 2'd3
    } pol_e;

    // Class of a unit given the per-class counts (units laid out by class)
    function automatic fu_cls_e unit_class(int u, int n_alu, int n_mul, int n_mem);
        if (u < n_alu)                     return CLS_ALU;
        else if (u < n_alu + n_mul)        return CLS_MUL;
        else if (u < n_alu + n_mul + n_mem) return CLS_MEM;
        else                               return CLS_FPU;
    endfunction

    function automatic int class_latency(fu_cls_e c, int l_alu, int l_mul, int l_mem, int l_fpu);
        case (c)
            CLS_ALU: return l_alu;
            CLS_MUL: return l_mul;
            CLS_MEM: return l_mem;
            default: return l_fpu;
        endcase
    endfunction

    // Policy-dependent preference bit; higher wins before age is compared
    function automatic logic policy_pref(pol_e p, logic is_br, logic is_spec);
        case (p)
            POL_BR_FIRST:  return is_br;
            POL_SPEC_LAST: return ~is_spec;
            default:       return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/smt_iss_rank.sv
module smt_iss_rank
    import smt_iss_pkg::*;
#(
    parameter int Q     = 8,
    parameter int TID_W = 2,
    parameter int AGE_W = 4,
    parameter int IDX_W = 3
) (
    input  pol_e                        pol_i,
    input  logic [Q-1:0]                elig_i,
    input  logic [Q-1:0][TID_W-1:0]     tid_i,
    input  logic [Q-1:0][AGE_W-1:0]     age_i,
    input  logic [Q-1:0]                br_i,
    input  logic [Q-1:0]                spec_i,
    output logic [Q-1:0][IDX_W-1:0]     pos_o
);

    logic [Q-1:0]     pref;
    logic [IDX_W-1:0] cnt;
    logic             win;

    // pos_o[e] = number of eligible entries that outrank entry e
    always_comb begin
        for (int e = 0; e < Q; e++) begin
            pref[e] = policy_pref(pol_i, br_i[e], spec_i[e]);
        end
        cnt = '0;
        win = 1'b0;
        for (int e = 0; e < Q; e++) begin
            cnt = '0;
            for (int f = 0; f < Q; f++) begin
                if (pref[f] != pref[e])
                    win = pref[f];
                else if (age_i[f] != age_i[e])
                    win = (age_i[f] > age_i[e]);
                else if (tid_i[f] != tid_i[e])
                    win = (tid_i[f] < tid_i[e]);
                else
                    win = (f < e);
                if (f != e && elig_i[f] && win)
                    cnt = cnt + IDX_W'(1);
            end
            pos_o[e] = cnt;
        end
    end

endmodule

// File: rtl/smt_iss_alloc.sv
module smt_iss_alloc #(
    parameter int Q      = 8,
    parameter int S      = 4,
    parameter int NU     = 10,
    parameter int IDX_W  = 3,
    parameter int UIDX_W = 4,
    parameter int SW     = 3
) (
    input  logic [Q-1:0]                 elig_i,
    input  logic [Q-1:0][IDX_W-1:0]      pos_i,
    input  logic [Q-1:0][1:0]            cls_i,
    input  logic [NU-1:0][1:0]           unit_cls_i,
    input  logic [NU-1:0]                avail_i,
    output logic [Q-1:0]                 grant_ent_o,
    output logic [NU-1:0]                grant_unit_o,
    output logic [S-1:0]                 slot_vld_o,
    output logic [S-1:0][IDX_W-1:0]      slot_idx_o,
    output logic [S-1:0][UIDX_W-1:0]     slot_unit_o,
    output logic [SW-1:0]                nfill_o
);

    logic [NU-1:0]     free;
    logic [SW-1:0]     nfill;
    logic              found;
    logic [UIDX_W-1:0] pick;

    // Walk priority positions in order; give each candidate the lowest free unit
    always_comb begin
        free         = avail_i;
        grant_ent_o  = '0;
        grant_unit_o = '0;
        slot_vld_o   = '0;
        slot_idx_o   = '0;
        slot_unit_o  = '0;
        nfill        = '0;
        found        = 1'b0;
        pick         = '0;
        for (int p = 0; p < Q; p++) begin
            for (int e = 0; e < Q; e++) begin
                if (elig_i[e] && pos_i[e] == IDX_W'(p) && nfill < SW'(S)) begin
                    found = 1'b0;
                    pick  = '0;
                    for (int u = 0; u < NU; u++) begin
                        if (!found && free[u] && unit_cls_i[u] == cls_i[e]) begin
                            found = 1'b1;
                            pick  = UIDX_W'(u);
                        end
                    end
                    if (found) begin
                        free[pick]         = 1'b0;
                        grant_ent_o[e]     = 1'b1;
                        grant_unit_o[pick] = 1'b1;
                        slot_vld_o[nfill]  = 1'b1;
                        slot_idx_o[nfill]  = IDX_W'(e);
                        slot_unit_o[nfill] = pick;
                        nfill              = nfill + SW'(1);
                    end
                end
            end
        end
        nfill_o = nfill;
    end

endmodule

// File: rtl/smt_iss_fu_pipe.sv
module smt_iss_fu_pipe #(
    parameter int LAT = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic issue_i,
    output logic done_o,
    output logic inflight_o
);

    logic [LAT-1:0] stage_q;

    generate
        if (LAT == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) stage_q <= '0;
                else     stage_q <= issue_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) stage_q <= '0;
                else     stage_q <= {stage_q[LAT-2:0], issue_i};
            end
        end
    endgenerate

    assign done_o     = stage_q[LAT-1];
    assign inflight_o = |stage_q;

    AST_DONE_AFTER_LAT: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(issue_i, LAT)); // R10

    AST_ISSUE_LEADS_TO_INFLIGHT: assert property (@(posedge clk) disable iff (rst)
        issue_i |=> inflight_o); // R10

endmodule

// File: rtl/smt_iss_waste.sv
module smt_iss_waste #(
    parameter int S     = 4,
    parameter int SW    = 3,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SW-1:0]    nfill_i,
    output logic [CNT_W-1:0] vert_o,
    output logic [CNT_W-1:0] horiz_o
);

    localparam logic [SW-1:0] SLOTS = SW'(S);

    logic [SW-1:0] gap;
    assign gap = SLOTS - nfill_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            vert_o  <= '0;
            horiz_o <= '0;
        end else if (nfill_i == '0) begin
            vert_o  <= vert_o + CNT_W'(1);
        end else begin
            horiz_o <= horiz_o + CNT_W'(gap);
        end
    end

    AST_WASTE_ONE_KIND: assert property (@(posedge clk) disable iff (rst)
        (vert_o != $past(vert_o)) |-> (horiz_o == $past(horiz_o))); // R11

endmodule

// File: rtl/smt_issue_select.sv
module smt_issue_select
    import smt_iss_pkg::*;
#(
    parameter int Q       = 8,
    parameter int S       = 4,
    parameter int TID_W   = 2,
    parameter int AGE_W   = 4,
    parameter int N_ALU   = 4,
    parameter int N_MUL   = 1,
    parameter int N_MEM   = 3,
    parameter int N_FPU   = 2,
    parameter int LAT_ALU = 1,
    parameter int LAT_MUL = 3,
    parameter int LAT_MEM = 2,
    parameter int LAT_FPU = 5,
    parameter int CNT_W   = 16,
    localparam int NU     = N_ALU + N_MUL + N_MEM + N_FPU,
    localparam int IDX_W  = $clog2(Q),
    localparam int UIDX_W = $clog2(NU),
    localparam int SW     = $clog2(S + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [1:0]            policy_i,
    input  logic [Q-1:0]          ent_valid_i,
    input  logic [Q-1:0]          ent_ready_i,
    input  logic [Q*TID_W-1:0]    ent_tid_i,
    input  logic [Q*AGE_W-1:0]    ent_age_i,
    input  logic [Q*2-1:0]        ent_cls_i,
    input  logic [Q-1:0]          ent_branch_i,
    input  logic [Q-1:0]          ent_spec_i,
    input  logic [NU-1:0]         unit_avail_i,
    output logic [S-1:0]          slot_vld_o,
    output logic [S*IDX_W-1:0]    slot_idx_o,
    output logic [S*UIDX_W-1:0]   slot_unit_o,
    output logic [Q-1:0]          ent_issued_o,
    output logic [NU-1:0]         unit_issue_o,
    output logic [NU-1:0]         unit_inflight_o,
    output logic [NU-1:0]         unit_done_o,
    output logic [CNT_W-1:0]      vert_waste_o,
    output logic [CNT_W-1:0]      horiz_waste_o
);

    logic [Q-1:0]              elig;
    logic [Q-1:0][IDX_W-1:0]   pos;
    logic [NU-1:0][1:0]        unit_cls;
    logic [Q-1:0]              grant_ent;
    logic [NU-1:0]             grant_unit;
    logic [S-1:0]              slot_vld_d;
    logic [S-1:0][IDX_W-1:0]   slot_idx_d;
    logic [S-1:0][UIDX_W-1:0]  slot_unit_d;
    logic [SW-1:0]             nfill;

    assign elig = ent_valid_i & ent_ready_i;

    // Constant class map of the unit pool
    generate
        for (genvar u = 0; u < NU; u++) begin : g_map
            assign unit_cls[u] = 2'(unit_class(u, N_ALU, N_MUL, N_MEM));
        end
    endgenerate

    smt_iss_rank #(
        .Q(Q), .TID_W(TID_W), .AGE_W(AGE_W), .IDX_W(IDX_W)
    ) u_rank (
        .pol_i  (pol_e'(policy_i)),
        .elig_i (elig),
        .tid_i  (ent_tid_i),
        .age_i  (ent_age_i),
        .br_i   (ent_branch_i),
        .spec_i (ent_spec_i),
        .pos_o  (pos)
    );

    smt_iss_alloc #(
        .Q(Q), .S(S), .NU(NU), .IDX_W(IDX_W), .UIDX_W(UIDX_W), .SW(SW)
    ) u_alloc (
        .elig_i       (elig),
        .pos_i        (pos),
        .cls_i        (ent_cls_i),
        .unit_cls_i   (unit_cls),
        .avail_i      (unit_avail_i),
        .grant_ent_o  (grant_ent),
        .grant_unit_o (grant_unit),
        .slot_vld_o   (slot_vld_d),
        .slot_idx_o   (slot_idx_d),
        .slot_unit_o  (slot_unit_d),
        .nfill_o      (nfill)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_vld_o   <= '0;
            slot_idx_o   <= '0;
            slot_unit_o  <= '0;
            ent_issued_o <= '0;
            unit_issue_o <= '0;
        end else begin
            slot_vld_o   <= slot_vld_d;
            slot_idx_o   <= slot_idx_d;
            slot_unit_o  <= slot_unit_d;
            ent_issued_o <= grant_ent;
            unit_issue_o <= grant_unit;
        end
    end

    generate
        for (genvar u = 0; u < NU; u++) begin : g_fu
            localparam int L = class_latency(unit_class(u, N_ALU, N_MUL, N_MEM),
                                             LAT_ALU, LAT_MUL, LAT_MEM, LAT_FPU);
            smt_iss_fu_pipe #(.LAT(L)) u_pipe (
                .clk        (clk),
                .rst        (rst),
                .issue_i    (unit_issue_o[u]),
                .done_o     (unit_done_o[u]),
                .inflight_o (unit_inflight_o[u])
            );

            AST_UNIT_WAS_FREE: assert property (@(posedge clk) disable iff (rst)
                unit_issue_o[u] |-> $past(unit_avail_i[u])); // R2
        end
    endgenerate

    smt_iss_waste #(.S(S), .SW(SW), .CNT_W(CNT_W)) u_waste (
        .clk     (clk),
        .rst     (rst),
        .nfill_i (nfill),
        .vert_o  (vert_waste_o),
        .horiz_o (horiz_waste_o)
    );

    generate
        for (genvar e = 0; e < Q; e++) begin : g_ent_chk
            AST_ISSUE_ONLY_ELIGIBLE: assert property (@(posedge clk) disable iff (rst)
                ent_issued_o[e] |-> $past(ent_valid_i[e] && ent_ready_i[e])); // R1
        end
        for (genvar k = 0; k + 1 < S; k++) begin : g_slot_chk
            AST_SLOTS_PACKED: assert property (@(posedge clk) disable iff (rst)
                slot_vld_o[k+1] |-> slot_vld_o[k]); // R8
        end
    endgenerate

    AST_GRANT_COUNTS_AGREE: assert property (@(posedge clk) disable iff (rst)
        ($countones(ent_issued_o) == $countones(slot_vld_o)) &&
        ($countones(unit_issue_o) == $countones(slot_vld_o))); // R8

    AST_SLOT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        $countones(ent_issued_o) <= S); // R1

endmodule

// File: tb/smt_issue_select_bench.sv
module smt_issue_select_bench;

    localparam int Q = 8, S = 4, TW = 2, AW = 4, CW = 16;
    localparam int NA = 4, NM = 1, NME = 3, NF = 2;
    localparam int NU = NA + NM + NME + NF;
    localparam int IW = 3, UW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0]       policy;
    logic [Q-1:0]     valid, ready, branch, spec;
    logic [Q*TW-1:0]  tid_v;
    logic [Q*AW-1:0]  age_v;
    logic [Q*2-1:0]   cls_v;
    logic [NU-1:0]    avail;
    logic [S-1:0]     slot_vld;
    logic [S*IW-1:0]  slot_idx;
    logic [S*UW-1:0]  slot_unit;
    logic [Q-1:0]     issued;
    logic [NU-1:0]    uiss, uinf, udone;
    logic [CW-1:0]    vwaste, hwaste;

    always #10 clk = ~clk;

    smt_issue_select u_smt_issue_select (
        .clk(clk), .rst(rst), .policy_i(policy),
        .ent_valid_i(valid), .ent_ready_i(ready), .ent_tid_i(tid_v),
        .ent_age_i(age_v), .ent_cls_i(cls_v), .ent_branch_i(branch),
        .ent_spec_i(spec), .unit_avail_i(avail),
        .slot_vld_o(slot_vld), .slot_idx_o(slot_idx), .slot_unit_o(slot_unit),
        .ent_issued_o(issued), .unit_issue_o(uiss), .unit_inflight_o(uinf),
        .unit_done_o(udone), .vert_waste_o(vwaste), .horiz_waste_o(hwaste)
    );

    int n_chk = 0, n_fail = 0;

    bit sv[Q], sr[Q], sbr[Q], ssp[Q];
    int stid[Q], sage[Q], scls[Q];
    bit sav[NU];
    int spol;

    bit [Q-1:0]  x_iss;
    bit [NU-1:0] x_uiss;
    bit [S-1:0]  x_svld;
    int          x_sidx[S], x_sunit[S];
    int          x_nfill;
    int          x_vert = 0, x_horiz = 0;
    bit [NU-1:0] hist[16];
    int          cyc = 16;

    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int cbase(int c);
        return (c == 0) ? 0 : (c == 1) ? NA : (c == 2) ? NA + NM : NA + NM + NME;
    endfunction
    function automatic int ccnt(int c);
        return (c == 0) ? NA : (c == 1) ? NM : (c == 2) ? NME : NF;
    endfunction
    function automatic int ulat(int u);
        if (u < NA) return 1;
        if (u < NA + NM) return 3;
        if (u < NA + NM + NME) return 2;
        return 5;
    endfunction

    function automatic bit pref(int e);
        if (spol == 1) return sbr[e];
        if (spol == 2) return !ssp[e];
        return 1'b0;
    endfunction

    function automatic bit better(int a, int b);
        if (pref(a) != pref(b)) return pref(a);
        if (sage[a] != sage[b]) return sage[a] > sage[b];
        if (stid[a] != stid[b]) return stid[a] < stid[b];
        return a < b;
    endfunction

    task automatic model();
        bit done[Q];
        bit fr[NU];
        x_iss = '0; x_uiss = '0; x_svld = '0; x_nfill = 0;
        for (int k = 0; k < S; k++) begin x_sidx[k] = 0; x_sunit[k] = 0; end
        for (int e = 0; e < Q; e++) done[e] = 1'b0;
        for (int u = 0; u < NU; u++) fr[u] = sav[u];
        for (int it = 0; it < Q; it++) begin
            int best = -1;
            for (int e = 0; e < Q; e++)
                if (sv[e] && sr[e] && !done[e] && (best < 0 || better(e, best))) best = e;
            if (best >= 0) begin
                int got = -1;
                done[best] = 1'b1;
                for (int u = cbase(scls[best]); u < cbase(scls[best]) + ccnt(scls[best]); u++)
                    if (got < 0 && fr[u]) got = u;
                if (got >= 0 && x_nfill < S) begin
                    fr[got] = 1'b0;
                    x_iss[best] = 1'b1;
                    x_uiss[got] = 1'b1;
                    x_svld[x_nfill] = 1'b1;
                    x_sidx[x_nfill] = best;
                    x_sunit[x_nfill] = got;
                    x_nfill++;
                end
            end
        end
    endtask

    task automatic apply();
        policy = 2'(spol);
        for (int e = 0; e < Q; e++) begin
            valid[e] = sv[e]; ready[e] = sr[e]; branch[e] = sbr[e]; spec[e] = ssp[e];
            tid_v[e*TW +: TW] = TW'(stid[e]);
            age_v[e*AW +: AW] = AW'(sage[e]);
            cls_v[e*2 +: 2]   = 2'(scls[e]);
        end
        for (int u = 0; u < NU; u++) avail[u] = sav[u];
    endtask

    task automatic clear_q();
        for (int e = 0; e < Q; e++) begin
            sv[e] = 0; sr[e] = 0; sbr[e] = 0; ssp[e] = 0; stid[e] = 0; sage[e] = 0; scls[e] = 0;
        end
        for (int u = 0; u < NU; u++) sav[u] = 1'b1;
        spol = 0;
    endtask

    task automatic put(int e, int t, int a, int c, bit b, bit s);
        sv[e] = 1; sr[e] = 1; stid[e] = t; sage[e] = a; scls[e] = c; sbr[e] = b; ssp[e] = s;
    endtask

    task automatic run_cycle(string tag);
        bit [NU-1:0] xd, xf;
        apply();
        model();
        @(posedge clk);
        @(negedge clk);
        hist[cyc % 16] = x_uiss;
        if (x_nfill == 0) x_vert++; else x_horiz += S - x_nfill;
        xd = '0; xf = '0;
        for (int u = 0; u < NU; u++) begin
            xd[u] = hist[(cyc - ulat(u)) % 16][u];
            for (int d = 1; d <= ulat(u); d++) xf[u] = xf[u] | hist[(cyc - d) % 16][u];
        end
        chk(slot_vld == x_svld, tag, 64'(slot_vld), 64'(x_svld));
        for (int k = 0; k < S; k++) begin
            if (x_svld[k]) begin
                chk(slot_idx[k*IW +: IW] == IW'(x_sidx[k]), tag, 64'(slot_idx[k*IW +: IW]), 64'(x_sidx[k]));
                chk(slot_unit[k*UW +: UW] == UW'(x_sunit[k]), "R8", 64'(slot_unit[k*UW +: UW]), 64'(x_sunit[k]));
            end
        end
        chk(issued == x_iss, "R1", 64'(issued), 64'(x_iss));
        chk(uiss == x_uiss, "R2", 64'(uiss), 64'(x_uiss));
        chk(udone == xd, "R10", 64'(udone), 64'(xd));
        chk(uinf == xf, "R10", 64'(uinf), 64'(xf));
        chk(vwaste == CW'(x_vert), "R11", 64'(vwaste), 64'(x_vert));
        chk(hwaste == CW'(x_horiz), "R11", 64'(hwaste), 64'(x_horiz));
        cyc++;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) hist[i] = '0;
        void'($urandom(32'd20240611));
        clear_q();
        apply();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R13: everything quiet during reset
        chk({slot_vld, issued, uiss, uinf, udone} == '0, "R13",
            64'({slot_vld, issued, uiss, uinf, udone}), 64'(0));
        chk(vwaste == '0 && hwaste == '0, "R13", 64'({vwaste, hwaste}), 64'(0));
        rst = 1'b0;

        // R11: empty queue is vertical waste
        clear_q(); run_cycle("R11");
        // R1: valid without ready and ready without valid never issue
        clear_q(); put(0, 0, 9, 0, 0, 0); sr[0] = 0; put(1, 1, 9, 0, 0, 0); sv[1] = 0;
        run_cycle("R1");
        // R3: second multiply blocked, younger ALU still goes
        clear_q(); put(0, 0, 15, 1, 0, 0); put(1, 1, 14, 1, 0, 0); put(2, 2, 3, 0, 0, 0);
        run_cycle("R3");
        // R10: let the multiply and ALU results drain
        clear_q(); run_cycle("R10"); run_cycle("R10"); run_cycle("R10");
        // R4: oldest four ALU entries out of six
        clear_q(); for (int e = 0; e < 6; e++) put(e, e % 4, e + 1, 0, 0, 0);
        run_cycle("R4");
        // policy code 3 behaves as oldest-first
        spol = 3; run_cycle("R4");
        // R5: young branches beat old non-branches
        clear_q(); spol = 1;
        for (int e = 0; e < 6; e++) put(e, e % 4, 10 - e, 0, (e >= 3), 0);
        run_cycle("R5");
        // R6: old speculative entries wait behind young ones
        clear_q(); spol = 2;
        for (int e = 0; e < 6; e++) put(e, e % 4, 10 - e, 0, 0, (e < 3));
        run_cycle("R6");
        // R7: equal ages resolved by thread id then index
        clear_q();
        put(0, 3, 7, 0, 0, 0); put(1, 1, 7, 0, 0, 0); put(2, 1, 7, 0, 0, 0);
        put(3, 2, 7, 0, 0, 0); put(4, 0, 7, 0, 0, 0); put(5, 0, 2, 0, 0, 0);
        run_cycle("R7");
        // R9: one entry from each thread, all in one cycle
        clear_q(); put(1, 0, 3, 0, 0, 0); put(3, 1, 4, 2, 0, 0); put(5, 2, 5, 3, 0, 0); put(7, 3, 6, 1, 0, 0);
        run_cycle("R9");
        // R2: only ALU unit 2 and FP unit 9 available
        clear_q(); for (int u = 0; u < NU; u++) sav[u] = (u == 2 || u == 9);
        put(0, 0, 5, 0, 0, 0); put(1, 1, 6, 0, 0, 0); put(2, 2, 7, 3, 0, 0); put(3, 3, 8, 3, 0, 0);
        run_cycle("R2");
        // R8: full slots, no waste added
        clear_q(); for (int e = 0; e < Q; e++) put(e, e % 4, e, 0, 0, 0);
        run_cycle("R8");
        clear_q(); for (int e = 0; e < 4; e++) put(e, e, 12 - e, 2, 0, 0);
        run_cycle("R8");

        // R12: random traffic, policy changing every cycle
        for (int i = 0; i < 1500; i++) begin
            for (int e = 0; e < Q; e++) begin
                sv[e] = ($urandom % 4) != 0;
                sr[e] = ($urandom % 4) != 0;
                stid[e] = int'($urandom % 4);
                sage[e] = int'($urandom % 16);
                scls[e] = int'($urandom % 4);
                sbr[e] = ($urandom % 3) == 0;
                ssp[e] = ($urandom % 3) == 0;
            end
            for (int u = 0; u < NU; u++) sav[u] = ($urandom % 8) != 0;
            spol = int'($urandom % 4);
            run_cycle("R12");
        end
        clear_q();
        for (int i = 0; i < 6; i++) run_cycle("R10");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule